// File: doc/BRIEF.md
# Audio Clock Divider Chain

This block derives a master clock and a serial bit clock from one audio reference input. It does this twice, once for the transmit side and once for the receive side, and each side has its own configuration. Everything runs in the system clock domain. The reference and the external master-clock inputs are sampled levels. The outputs are registered levels that change on system clock edges, so downstream logic can use them directly as clock enables.

A side in the divide path runs the reference through a chain of stages:
- an optional prescaler that divides by 8;
- a modulus counter;
- a toggle stage that divides by 2 and produces the master clock;
- a final divider that counts master-clock edges and toggles the bit clock.

Each side has a small state machine with three states, and it picks where the master clock comes from:
- `SRC_DIVIDE` uses the divider chain.
- `SRC_BYPASS` passes the reference straight through.
- `SRC_EXTERNAL` takes the master clock from a pin input. In this state the side stops driving its master-clock pin.

There is only one transition, `state -> requested source`. It fires when the final divider reaches its terminal count. The requested source is worked out from the configuration like this:
- drive bit low gives `SRC_EXTERNAL`;
- otherwise, bypass bit high gives `SRC_BYPASS`;
- otherwise the request is `SRC_DIVIDE`.

Top module: `audclk_div_chain`

## Requirements
- R1: Synchronous reset (`rst` high) forces, from the following clock edge: both master clocks low, both bit clocks low, both pin-drive outputs high, the `SRC_DIVIDE` state, every counter zero and every active divider value at ÷1.
- R2: In `SRC_DIVIDE`, the master clock toggles once every P×M rising edges of the reference, giving a period of 2×P×M reference periods at 50% duty. P is 1 when the prescaler bit is 0 and 8 when it is 1; no other prescale exists. M is the 8-bit modulus field plus one.
- R3: The bit clock toggles once every F edges (rising and falling) of the selected master clock, giving a period of F master-clock periods at 50% duty for any F. F is the 4-bit final field plus one.
- R4: In `SRC_BYPASS`, the master clock equals the reference as sampled on the previous clock edge, and the bit clock counts reference edges.
- R5: In `SRC_EXTERNAL`, the pin-drive output is low, the master clock equals the side's external input as sampled on the previous clock edge, and the bit clock counts edges of that input.
- R6: A changed prescale, modulus or final value only takes effect at the next terminal count of its own stage. A changed source selection only takes effect at the bit clock's terminal count, so the pin-drive output never changes except on a bit-clock toggle.
- R7: The transmit and receive sides share only the reference and the system clock. A setting on one side never changes the outputs of the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Audio reference level, synchronous to clk |
| tx_pre_div8 | input | 1 | Transmit prescaler: 0 = ÷1, 1 = ÷8 |
| tx_mod_m1 | input | 8 | Transmit modulus minus one |
| tx_fin_m1 | input | 4 | Transmit final divide minus one |
| tx_bypass | input | 1 | Transmit: reference passed straight to master clock |
| tx_drive | input | 1 | Transmit: 1 = drive master-clock pin, 0 = take it from input |
| tx_ext_mclk | input | 1 | Transmit external master clock level |
| rx_pre_div8 | input | 1 | Receive prescaler: 0 = ÷1, 1 = ÷8 |
| rx_mod_m1 | input | 8 | Receive modulus minus one |
| rx_fin_m1 | input | 4 | Receive final divide minus one |
| rx_bypass | input | 1 | Receive: reference passed straight to master clock |
| rx_drive | input | 1 | Receive: 1 = drive master-clock pin, 0 = take it from input |
| rx_ext_mclk | input | 1 | Receive external master clock level |
| tx_mclk | output | 1 | Transmit master clock |
| tx_bclk | output | 1 | Transmit bit clock |
| tx_mclk_oe | output | 1 | Transmit master-clock pin drive enable |
| rx_mclk | output | 1 | Receive master clock |
| rx_bclk | output | 1 | Receive bit clock |
| rx_mclk_oe | output | 1 | Receive master-clock pin drive enable |

## Verification
The assertions assume that `ref_in` and both external master-clock inputs are already synchronous to `clk`. They assume a one-cycle sampling delay is the only path from those inputs to `*_mclk`, and that reset is held for at least two cycles. The stimulus meets these assumptions in three ways. It drives every input one nanosecond after a rising edge. It holds reset for four cycles. It toggles the reference every two cycles and the external clocks every three cycles, so no edge is ever shorter than a clock period. Configuration is changed in the middle of a count, so the deferred-load rule is exercised rather than avoided.

// File: rtl/acd_pkg.sv
package acd_pkg;

    typedef enum logic [1:0] {
        SRC_DIVIDE   = 2'd0,
        SRC_BYPASS   = 2'd1,
        SRC_EXTERNAL = 2'd2
    } src_mode_e;

    localparam int ACD_SIDES = 2;

endpackage

// File: rtl/acd_prescale.sv
module acd_prescale #(
    parameter int PRE_RATIO = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic cfg_div,
    output logic p_tick
);
    localparam int CW = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRE_RATIO - 1);

    logic [CW-1:0] cnt;
    logic          div_act;
    logic          at_last;

    // without the prescaler every rising edge is a terminal count
    assign at_last = !div_act || (cnt == LAST);
    assign p_tick  = ref_rise && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            div_act <= 1'b0;
        end else if (ref_rise) begin
            if (at_last) begin
                cnt     <= '0;
                div_act <= cfg_div;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/acd_modulus.sv
module acd_modulus #(
    parameter int MOD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             p_tick,
    input  logic [MOD_W-1:0] cfg_mod,
    output logic             m_wrap,
    output logic             mclk_div
);
    logic [MOD_W-1:0] cnt;
    logic [MOD_W-1:0] mod_act;

    assign m_wrap = p_tick && (cnt == mod_act);

    // the toggle register is the fixed divide-by-two stage
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            mod_act  <= '0;
            mclk_div <= 1'b0;
        end else if (p_tick) begin
            if (m_wrap) begin
                cnt      <= '0;
                mod_act  <= cfg_mod;
                mclk_div <= ~mclk_div;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/acd_final.sv
module acd_final
    import acd_pkg::*;
#(
    parameter int FIN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             m_wrap,
    input  logic             mclk_div,
    input  logic             ref_now,
    input  logic             ref_q,
    input  logic             ext_now,
    input  logic             ext_q,
    input  logic [FIN_W-1:0] cfg_fin,
    input  logic             cfg_bypass,
    input  logic             cfg_drive,
    output logic             mclk,
    output logic             bclk,
    output logic             mclk_oe
);
    src_mode_e        state;
    src_mode_e        state_nx;
    src_mode_e        mode_req;
    logic [FIN_W-1:0] fcnt;
    logic [FIN_W-1:0] fin_act;
    logic             src_edge;
    logic             f_wrap;

    // an edge of the selected master clock, one cycle before it shows
    always_comb begin
        unique case (state)
            SRC_DIVIDE:   src_edge = m_wrap;
            SRC_BYPASS:   src_edge = (ref_now != ref_q);
            SRC_EXTERNAL: src_edge = (ext_now != ext_q);
            default:      src_edge = 1'b0;
        endcase
    end

    assign f_wrap = src_edge && (fcnt == fin_act);

    always_comb begin
        if (!cfg_drive) begin
            mode_req = SRC_EXTERNAL;
        end else if (cfg_bypass) begin
            mode_req = SRC_BYPASS;
        end else begin
            mode_req = SRC_DIVIDE;
        end
    end

    assign state_nx = f_wrap ? mode_req : state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SRC_DIVIDE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt    <= '0;
            fin_act <= '0;
            bclk    <= 1'b0;
        end else if (src_edge) begin
            if (f_wrap) begin
                fcnt    <= '0;
                fin_act <= cfg_fin;
                bclk    <= ~bclk;
            end else begin
                fcnt <= fcnt + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            SRC_DIVIDE: begin
                mclk    = mclk_div;
                mclk_oe = 1'b1;
            end
            SRC_BYPASS: begin
                mclk    = ref_q;
                mclk_oe = 1'b1;
            end
            SRC_EXTERNAL: begin
                mclk    = ext_q;
                mclk_oe = 1'b0;
            end
            default: begin
                mclk    = 1'b0;
                mclk_oe = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/audclk_div_chain.sv
module audclk_div_chain
    import acd_pkg::*;
#(
    parameter int PRE_RATIO = 8,
    parameter int MOD_W     = 8,
    parameter int FIN_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             tx_pre_div8,
    input  logic [MOD_W-1:0] tx_mod_m1,
    input  logic [FIN_W-1:0] tx_fin_m1,
    input  logic             tx_bypass,
    input  logic             tx_drive,
    input  logic             tx_ext_mclk,
    input  logic             rx_pre_div8,
    input  logic [MOD_W-1:0] rx_mod_m1,
    input  logic [FIN_W-1:0] rx_fin_m1,
    input  logic             rx_bypass,
    input  logic             rx_drive,
    input  logic             rx_ext_mclk,
    output logic             tx_mclk,
    output logic             tx_bclk,
    output logic             tx_mclk_oe,
    output logic             rx_mclk,
    output logic             rx_bclk,
    output logic             rx_mclk_oe
);
    localparam int NS = ACD_SIDES;

    logic                 ref_q;
    logic                 ref_rise;
    logic [NS-1:0]        pre_v;
    logic [NS-1:0]        byp_v;
    logic [NS-1:0]        drv_v;
    logic [NS-1:0]        ext_v;
    logic [NS-1:0]        mclk_v;
    logic [NS-1:0]        bclk_v;
    logic [NS-1:0]        oe_v;
    logic [MOD_W-1:0]     mod_v [NS];
    logic [FIN_W-1:0]     fin_v [NS];

    // index 0 is transmit, index 1 is receive
    assign pre_v    = {rx_pre_div8, tx_pre_div8};
    assign byp_v    = {rx_bypass, tx_bypass};
    assign drv_v    = {rx_drive, tx_drive};
    assign ext_v    = {rx_ext_mclk, tx_ext_mclk};
    assign mod_v[0] = tx_mod_m1;
    assign mod_v[1] = rx_mod_m1;
    assign fin_v[0] = tx_fin_m1;
    assign fin_v[1] = rx_fin_m1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= ref_in;
        end
    end

    assign ref_rise = ref_in && !ref_q;

    for (genvar s = 0; s < NS; s++) begin : g_side
        logic ext_q;
        logic p_tick;
        logic m_wrap;
        logic mclk_div;

        always_ff @(posedge clk) begin
            if (rst) begin
                ext_q <= 1'b0;
            end else begin
                ext_q <= ext_v[s];
            end
        end

        acd_prescale #(
            .PRE_RATIO (PRE_RATIO)
        ) u_pre (
            .clk      (clk),
            .rst      (rst),
            .ref_rise (ref_rise),
            .cfg_div  (pre_v[s]),
            .p_tick   (p_tick)
        );

        acd_modulus #(
            .MOD_W (MOD_W)
        ) u_mod (
            .clk      (clk),
            .rst      (rst),
            .p_tick   (p_tick),
            .cfg_mod  (mod_v[s]),
            .m_wrap   (m_wrap),
            .mclk_div (mclk_div)
        );

        acd_final #(
            .FIN_W (FIN_W)
        ) u_fin (
            .clk        (clk),
            .rst        (rst),
            .m_wrap     (m_wrap),
            .mclk_div   (mclk_div),
            .ref_now    (ref_in),
            .ref_q      (ref_q),
            .ext_now    (ext_v[s]),
            .ext_q      (ext_q),
            .cfg_fin    (fin_v[s]),
            .cfg_bypass (byp_v[s]),
            .cfg_drive  (drv_v[s]),
            .mclk       (mclk_v[s]),
            .bclk       (bclk_v[s]),
            .mclk_oe    (oe_v[s])
        );
    end

    assign tx_mclk    = mclk_v[0];
    assign tx_bclk    = bclk_v[0];
    assign tx_mclk_oe = oe_v[0];
    assign rx_mclk    = mclk_v[1];
    assign rx_bclk    = bclk_v[1];
    assign rx_mclk_oe = oe_v[1];

endmodule

// File: rtl/acd_checker.sv
module acd_checker (
    input logic clk,
    input logic rst,
    input logic tx_ext_mclk,
    input logic rx_ext_mclk,
    input logic tx_mclk,
    input logic tx_bclk,
    input logic tx_mclk_oe,
    input logic rx_mclk,
    input logic rx_bclk,
    input logic rx_mclk_oe
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q === 1'b1) begin
            assert_reset_state_R1 : assert (!tx_mclk && !tx_bclk && tx_mclk_oe &&
                                            !rx_mclk && !rx_bclk && rx_mclk_oe)
                else $error("R1 outputs not in reset state");
        end
    end

    assert_tx_ext_follow_R5 : assert property (@(posedge clk) disable iff (rst)
        !tx_mclk_oe |-> (tx_mclk == $past(tx_ext_mclk)));
    assert_rx_ext_follow_R5 : assert property (@(posedge clk) disable iff (rst)
        !rx_mclk_oe |-> (rx_mclk == $past(rx_ext_mclk)));

    assert_tx_oe_at_wrap_R6 : assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_mclk_oe) |-> !$stable(tx_bclk));
    assert_rx_oe_at_wrap_R6 : assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_mclk_oe) |-> !$stable(rx_bclk));

    // while the source stays external, each bit-clock edge rides a master-clock edge
    assert_tx_ext_bclk_R3 : assert property (@(posedge clk) disable iff (rst)
        (!tx_mclk_oe && !$past(tx_mclk_oe) && !$stable(tx_bclk)) |-> !$stable(tx_mclk));
    assert_rx_ext_bclk_R3 : assert property (@(posedge clk) disable iff (rst)
        (!rx_mclk_oe && !$past(rx_mclk_oe) && !$stable(rx_bclk)) |-> !$stable(rx_mclk));

endmodule

bind audclk_div_chain acd_checker u_acd_checker (
    .clk         (clk),
    .rst         (rst),
    .tx_ext_mclk (tx_ext_mclk),
    .rx_ext_mclk (rx_ext_mclk),
    .tx_mclk     (tx_mclk),
    .tx_bclk     (tx_bclk),
    .tx_mclk_oe  (tx_mclk_oe),
    .rx_mclk     (rx_mclk),
    .rx_bclk     (rx_bclk),
    .rx_mclk_oe  (rx_mclk_oe)
);

// File: tb/test_audclk_div_chain.sv
`timescale 1ns/100ps
module test_audclk_div_chain;

    logic       clk = 1'b0;
    logic       rst;
    logic       ref_in;
    logic       tx_pre, rx_pre, tx_byp, rx_byp, tx_drv, rx_drv;
    logic [7:0] tx_mod, rx_mod;
    logic [3:0] tx_fin, rx_fin;
    logic       tx_ext, rx_ext;
    logic       tx_mclk, tx_bclk, tx_oe, rx_mclk, rx_bclk, rx_oe;

    always #2 clk = ~clk;

    audclk_div_chain i_audclk_div_chain (
        .clk         (clk),
        .rst         (rst),
        .ref_in      (ref_in),
        .tx_pre_div8 (tx_pre),
        .tx_mod_m1   (tx_mod),
        .tx_fin_m1   (tx_fin),
        .tx_bypass   (tx_byp),
        .tx_drive    (tx_drv),
        .tx_ext_mclk (tx_ext),
        .rx_pre_div8 (rx_pre),
        .rx_mod_m1   (rx_mod),
        .rx_fin_m1   (rx_fin),
        .rx_bypass   (rx_byp),
        .rx_drive    (rx_drv),
        .rx_ext_mclk (rx_ext),
        .tx_mclk     (tx_mclk),
        .tx_bclk     (tx_bclk),
        .tx_mclk_oe  (tx_oe),
        .rx_mclk     (rx_mclk),
        .rx_bclk     (rx_bclk),
        .rx_mclk_oe  (rx_oe)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag   = "R1";
    bit    started = 0;
    bit    done    = 0;

    // behavioural reference state; mode 0 divide, 1 bypass, 2 external
    int m_refq;
    int m_extq [2];
    int m_pcnt [2];
    int m_pon  [2];
    int m_mcnt [2];
    int m_mlim [2];
    int m_fcnt [2];
    int m_flim [2];
    int m_mode [2];
    int m_mdiv [2];
    int m_bclk [2];

    always @(posedge clk) begin
        if (rst) begin
            m_refq = 0;
            for (int s = 0; s < 2; s++) begin
                m_extq[s] = 0; m_pcnt[s] = 0; m_pon[s] = 0; m_mcnt[s] = 0;
                m_mlim[s] = 1; m_fcnt[s] = 0; m_flim[s] = 1; m_mode[s] = 0;
                m_mdiv[s] = 0; m_bclk[s] = 0;
            end
            started = 1;
        end else begin
            for (int s = 0; s < 2; s++) begin
                int rise, ptick, mwrap, edge_now, want, ext;
                ext   = (s == 0) ? int'(tx_ext) : int'(rx_ext);
                rise  = (ref_in == 1'b1 && m_refq == 0) ? 1 : 0;
                ptick = 0;
                if (rise == 1) begin
                    m_pcnt[s] = m_pcnt[s] + 1;
                    if (m_pcnt[s] >= (m_pon[s] ? 8 : 1)) begin
                        ptick = 1;
                        m_pcnt[s] = 0;
                        m_pon[s] = (s == 0) ? int'(tx_pre) : int'(rx_pre);
                    end
                end
                mwrap = 0;
                if (ptick == 1) begin
                    m_mcnt[s] = m_mcnt[s] + 1;
                    if (m_mcnt[s] >= m_mlim[s]) begin
                        mwrap = 1;
                        m_mcnt[s] = 0;
                        m_mlim[s] = ((s == 0) ? int'(tx_mod) : int'(rx_mod)) + 1;
                        m_mdiv[s] = 1 - m_mdiv[s];
                    end
                end
                if (m_mode[s] == 0)      edge_now = mwrap;
                else if (m_mode[s] == 1) edge_now = (int'(ref_in) != m_refq) ? 1 : 0;
                else                     edge_now = (ext != m_extq[s]) ? 1 : 0;
                if (edge_now == 1) begin
                    m_fcnt[s] = m_fcnt[s] + 1;
                    if (m_fcnt[s] >= m_flim[s]) begin
                        m_fcnt[s] = 0;
                        m_flim[s] = ((s == 0) ? int'(tx_fin) : int'(rx_fin)) + 1;
                        m_bclk[s] = 1 - m_bclk[s];
                        if (((s == 0) ? tx_drv : rx_drv) == 1'b0)      want = 2;
                        else if (((s == 0) ? tx_byp : rx_byp) == 1'b1) want = 1;
                        else                                           want = 0;
                        m_mode[s] = want;
                    end
                end
                m_extq[s] = ext;
            end
            m_refq = int'(ref_in);
        end
    end

    function automatic int exp_mclk(int s);
        if (m_mode[s] == 1) return m_refq;
        if (m_mode[s] == 2) return m_extq[s];
        return m_mdiv[s];
    endfunction

    task automatic check1(string what, logic act, int expv);
        n_cmp++;
        if (act !== expv[0]) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %b expected %0d", tag, what, $time, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check1("tx_mclk", tx_mclk, exp_mclk(0));
            check1("tx_bclk", tx_bclk, m_bclk[0]);
            check1("tx_oe",   tx_oe,   (m_mode[0] == 2) ? 0 : 1);
            check1("rx_mclk", rx_mclk, exp_mclk(1));
            check1("rx_bclk", rx_bclk, m_bclk[1]);
            check1("rx_oe",   rx_oe,   (m_mode[1] == 2) ? 0 : 1);
        end
    end

    initial begin
        ref_in = 1'b0;
        forever begin
            repeat (2) @(posedge clk);
            #1 ref_in = ~ref_in;
        end
    end

    initial begin
        tx_ext = 1'b0;
        rx_ext = 1'b1;
        forever begin
            repeat (3) @(posedge clk);
            #1;
            tx_ext = ~tx_ext;
            rx_ext = ~rx_ext;
        end
    end

    task automatic run(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        tx_pre = 0; tx_mod = 8'd0; tx_fin = 4'd0; tx_byp = 0; tx_drv = 1;
        rx_pre = 0; rx_mod = 8'd0; rx_fin = 4'd0; rx_byp = 0; rx_drv = 1;
        tag = "R1";
        run(4);
        rst = 1'b0;
        // R2: divide mode, P=1 M=3 on transmit, P=8 M=1 on receive
        tag = "R2";
        tx_mod = 8'd2; tx_fin = 4'd1;
        rx_pre = 1;
        run(600);
        // R3: odd and even final divides
        tag = "R3";
        tx_fin = 4'd4; rx_fin = 4'd2;
        run(900);
        // R6: modulus changed mid-count, then again
        tag = "R6";
        tx_mod = 8'd5;
        run(37);
        tx_mod = 8'd1; rx_pre = 0;
        run(400);
        // R4: transmit bypass, source switch waits for a bit-clock wrap
        tag = "R4";
        tx_byp = 1; tx_fin = 4'd2;
        run(300);
        // R5: receive takes its master clock from the pin
        tag = "R5";
        rx_drv = 0; rx_fin = 4'd1;
        run(300);
        // R7: transmit reconfigured while receive stays external
        tag = "R7";
        tx_byp = 0; tx_pre = 1; tx_mod = 8'd0; tx_fin = 4'd0;
        run(400);
        // R1 again: reset in the middle of activity
        tag = "R1";
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        run(200);
        finish_run();
    end

endmodule